// File: doc/BRIEF.md
# Transponder Read Stream Sequencer

This block decides which memory bit a contactless tag sends to its load modulator on every field clock. It holds an eight-word by 33-bit memory, written through a preload port, and a mode register copied from word 0. After reset it stays silent for a fixed start-up window. Then it loops over the user words. It sends bits 1 to 32 of each word, one per bit period. It never sends bit 0, the lock bit.

Block terminators and sequence terminators are optional framing patterns that help a reader synchronise. The mode register is refreshed from word 0 each time a new word begins. A stop pulse silences the block until reset. An answer-on-request setting keeps the block silent until a wake pulse arrives. A resume pulse restarts the stream after a write attempt. After a successful write, streaming restarts at the programmed word. After a failed write, it restarts at the head of the loop. A mode-changed flag on the resume pulse keeps the old mode for the first word that is resent.

The encoder, the write-gap decoder and the programming engine sit outside this block. They connect only through the pulses and the serial outputs.

Top module: `rd_stream_seq`

## Requirements
- R1: After reset is released, `mod_en`, `bit_clk`, `tx_bit` and `tx_damp` stay low for STARTUP (256) rising edges. If answer-on-request is clear, the first bit period begins on the 256th edge, so `mod_en`, `bit_clk` and `cur_blk` = first word are seen right after it.
- R2: When the start window ends, `mode_o` takes the value of word 0. Mode fields are: bits 3:1 last word of the loop (LAST), bits 6:4 rate code, bit 7 block terminator enable, bit 8 sequence terminator enable, bit 9 answer-on-request.
- R3: Rate codes 0 to 7 give bit periods of 8, 16, 32, 40, 50, 64, 100 and 128 clocks. `bit_clk` is high on the first clock of each period. The rate held in `mode_o` applies.
- R4: A word is sent on `tx_bit` as its bits 1, 2, ... 32, in that order, one per bit period. Bit 0 is never sent. `cur_blk` shows the word being sent.
- R5: With LAST = n ≥ 1, words 1 to n are sent in order, and then word 1 follows again.
- R6: With LAST = 0, word 0 is sent over and over, and no sequence terminator is ever inserted.
- R7: With block terminators enabled, every word is preceded by two bit periods. In the first, `tx_damp` = 1 and `tx_bit` = 0. In the second, `tx_damp` = 0 and `tx_bit` = 1.
- R8: With sequence terminators enabled and LAST ≠ 0, a word numbered LAST or higher is followed by four terminator periods (damp, one, damp, one). Then the loop head follows, still preceded by its own block terminator if that is enabled.
- R9: `mode_o` reloads from word 0 on the first clock of each word, and at no other time while sending. A write to word 0 in the middle of a word shows only at the next word.
- R10: A resume pulse with `rsm_err` = 0 restarts the stream on the next edge at word `rsm_blk`. That word is preceded by a terminator if either terminator enable is set. With `rsm_err` = 1, the stream restarts at the loop head (word 1, or word 0 when LAST = 0) under the normal framing rule. After the resumed word, a word below LAST is followed by its successor; otherwise the loop head follows. A resume during the start window is ignored.
- R11: A successful resume with `rsm_mchg` = 1 sends the resumed word without refreshing `mode_o`. The refresh happens at the following word.
- R12: If answer-on-request is set when the start window ends, `mod_en` stays low until a wake pulse. The wake pulse starts the loop head. A resume also ends the silence. A wake pulse in any other state is ignored.
- R13: After a stop pulse, `mod_en`, `tx_bit` and `tx_damp` are low from the next edge until reset. Wake and resume pulses are then ignored.
- R14: When events meet on one edge, stop wins over resume, resume over wake, and wake over normal sequencing. A resume on the last clock of a word replaces that word's natural successor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Active-low reset |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 3 | Preload word address |
| pl_data | input | 33 | Preload word, bit 0 is the lock bit |
| wake_i | input | 1 | Wake pulse for answer-on-request silence |
| stop_i | input | 1 | Stop pulse, silences until reset |
| rsm_i | input | 1 | Resume pulse after a write attempt |
| rsm_blk | input | 3 | Word just programmed |
| rsm_err | input | 1 | Write attempt failed |
| rsm_mchg | input | 1 | Word 0 was reprogrammed |
| mod_en | output | 1 | Modulation active |
| bit_clk | output | 1 | First clock of a bit period |
| tx_bit | output | 1 | Bit value for the encoder |
| tx_damp | output | 1 | Continuous damping period of a terminator |
| cur_blk | output | 3 | Word being sent |
| mode_o | output | 33 | Mode register |

## Verification
The sharpest collision is a resume pulse that lands on the last clock of a word's final bit period. On that same edge the sequencer would otherwise start the next word or a sequence terminator. The bench waits until its reference model shows the final clock of a word, raises the resume on exactly that edge, and then compares every output on every following clock. This shows that the resumed word and its forced terminator replace the natural successor. A stop pulse and a resume pulse are also raised on one edge; the bench judges that modulation is low from then on, and that later wake and resume pulses leave it low.

// File: rtl/rd_stream_seq.sv
module rd_stream_seq #(
  parameter int NBLK    = 8,
  parameter int W       = 33,
  parameter int STARTUP = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pl_we,
  input  logic [$clog2(NBLK)-1:0]  pl_addr,
  input  logic [W-1:0]             pl_data,
  input  logic                     wake_i,
  input  logic                     stop_i,
  input  logic                     rsm_i,
  input  logic [$clog2(NBLK)-1:0]  rsm_blk,
  input  logic                     rsm_err,
  input  logic                     rsm_mchg,
  output logic                     mod_en,
  output logic                     bit_clk,
  output logic                     tx_bit,
  output logic                     tx_damp,
  output logic [$clog2(NBLK)-1:0]  cur_blk,
  output logic [W-1:0]             mode_o
);
  localparam int AW    = $clog2(NBLK);
  localparam int IW    = $clog2(W);
  localparam int DB    = W - 1;
  localparam int CW    = $clog2(STARTUP > 128 ? STARTUP : 128) + 1;
  localparam int MB_LO = 1;
  localparam int RT_LO = AW + 1;
  localparam int BT_B  = AW + 4;
  localparam int ST_B  = AW + 5;
  localparam int AOR_B = AW + 6;

  typedef enum logic [1:0] {S_BOOT, S_QUIET, S_RUN, S_HALT} st_t;
  typedef enum logic [1:0] {P_BT, P_DAT, P_ST} ph_t;

  logic [W-1:0]  mem [NBLK];
  logic [W-1:0]  mode;
  st_t           st;
  ph_t           ph;
  logic [IW-1:0] idx;
  logic [AW-1:0] blk;
  logic [CW-1:0] cnt;

  function automatic logic [7:0] per_of(input logic [2:0] r);
    case (r)
      3'd0: return 8'd8;
      3'd1: return 8'd16;
      3'd2: return 8'd32;
      3'd3: return 8'd40;
      3'd4: return 8'd50;
      3'd5: return 8'd64;
      3'd6: return 8'd100;
      default: return 8'd128;
    endcase
  endfunction

  always_ff @(posedge clk)
    if (pl_we) mem[pl_addr] <= pl_data;

  logic [W-1:0]  boot_w, nm, cur_w;
  logic [AW-1:0] mb, first_b, u_blk;
  logic [CW-1:0] per_m1;
  logic          per_end, go, u_ref, u_frc, to_st;
  logic [IW-1:0] bpos;

  assign boot_w  = mem[0];
  assign cur_w   = mem[blk];
  assign mb      = mode[MB_LO +: AW];
  assign first_b = (boot_w[MB_LO +: AW] == '0) ? '0 : AW'(1);
  assign per_m1  = CW'(per_of(mode[RT_LO +: 3])) - CW'(1);
  assign per_end = (cnt == per_m1);

  always_comb begin
    go    = 1'b0;
    u_blk = first_b;
    u_ref = 1'b1;
    u_frc = 1'b0;
    to_st = 1'b0;
    if (st == S_HALT || stop_i) begin
      go = 1'b0;
    end else if (rsm_i && st != S_BOOT) begin
      go = 1'b1;
      if (!rsm_err) begin
        u_blk = rsm_blk;
        u_ref = !rsm_mchg;
        u_frc = 1'b1;
      end
    end else if (wake_i && st == S_QUIET) begin
      go = 1'b1;
    end else if (st == S_BOOT) begin
      go = (cnt == CW'(STARTUP - 1)) && !boot_w[AOR_B];
    end else if (st == S_RUN && per_end) begin
      if (ph == P_ST && idx == IW'(3)) begin
        go = 1'b1;
      end else if (ph == P_DAT && idx == IW'(DB - 1)) begin
        if (blk < mb) begin
          go    = 1'b1;
          u_blk = blk + AW'(1);
        end else if (mode[ST_B] && mb != '0) begin
          to_st = 1'b1;
        end else begin
          go = 1'b1;
        end
      end
    end
  end

  assign nm = u_ref ? boot_w : mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_BOOT;
      ph   <= P_DAT;
      idx  <= '0;
      blk  <= '0;
      cnt  <= '0;
      mode <= '0;
    end else if (stop_i) begin
      st <= S_HALT;
    end else if (go) begin
      st   <= S_RUN;
      mode <= nm;
      blk  <= u_blk;
      cnt  <= '0;
      idx  <= '0;
      ph   <= (nm[BT_B] || (u_frc && nm[ST_B])) ? P_BT : P_DAT;
    end else begin
      case (st)
        S_BOOT:
          if (cnt == CW'(STARTUP - 1)) begin
            mode <= boot_w;
            st   <= S_QUIET;
            cnt  <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        S_RUN:
          if (per_end) begin
            cnt <= '0;
            if (to_st) begin
              ph  <= P_ST;
              idx <= '0;
            end else if (ph == P_BT && idx == IW'(1)) begin
              ph  <= P_DAT;
              idx <= '0;
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        default: ;
      endcase
    end
  end

  assign bpos    = idx + IW'(1);
  assign mod_en  = (st == S_RUN);
  assign bit_clk = mod_en && (cnt == '0);
  assign tx_damp = mod_en && (ph != P_DAT) && !idx[0];
  assign tx_bit  = mod_en && ((ph != P_DAT) ? idx[0] : cur_w[bpos]);
  assign cur_blk = blk;
  assign mode_o  = mode;
endmodule

// File: rtl/rd_stream_seq_chk.sv
module rd_stream_seq_chk #(
  parameter int W       = 33,
  parameter int STARTUP = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_i,
  input logic         mod_en,
  input logic         bit_clk,
  input logic         tx_bit,
  input logic         tx_damp,
  input logic [W-1:0] mode_o
);
  int unsigned since;
  logic        halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since  <= 0;
      halted <= 1'b0;
    end else begin
      if (since < STARTUP) since <= since + 1;
      if (stop_i) halted <= 1'b1;
    end
  end

  // R1
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> since >= STARTUP);

  // R3
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_en) |-> bit_clk);

  // R7
  damp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_damp |-> (mod_en && !tx_bit));

  // R13
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mod_en);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !bit_clk) |-> $stable(mode_o));
endmodule

bind rd_stream_seq rd_stream_seq_chk #(.W(W), .STARTUP(STARTUP)) chk_i (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mod_en(mod_en),
  .bit_clk(bit_clk), .tx_bit(tx_bit), .tx_damp(tx_damp), .mode_o(mode_o)
);

// File: tb/rd_stream_seq_tb_top.sv
`timescale 1ns/100ps
module rd_stream_seq_tb_top;
  localparam int NB = 8;
  localparam int W  = 33;
  localparam int SU = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          pl_we = 1'b0;
  logic [2:0]    pl_addr = '0;
  logic [W-1:0]  pl_data = '0;
  logic          wake_i = 1'b0, stop_i = 1'b0, rsm_i = 1'b0;
  logic [2:0]    rsm_blk = '0;
  logic          rsm_err = 1'b0, rsm_mchg = 1'b0;
  logic          mod_en, bit_clk, tx_bit, tx_damp;
  logic [2:0]    cur_blk;
  logic [W-1:0]  mode_o;

  rd_stream_seq #(.NBLK(NB), .W(W), .STARTUP(SU)) dut_i (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .wake_i(wake_i), .stop_i(stop_i), .rsm_i(rsm_i), .rsm_blk(rsm_blk),
    .rsm_err(rsm_err), .rsm_mchg(rsm_mchg), .mod_en(mod_en), .bit_clk(bit_clk),
    .tx_bit(tx_bit), .tx_damp(tx_damp), .cur_blk(cur_blk), .mode_o(mode_o)
  );

  int    errs = 0, checks = 0;
  string req = "R1";

  logic [W-1:0] mm [NB];
  logic [W-1:0] m_mode;
  int m_st, m_cnt, m_blk;
  int q[$];
  bit m_inst;

  function automatic int period(logic [2:0] r);
    case (r)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 40;
      3'd4: return 50;  3'd5: return 64;  3'd6: return 100; default: return 128;
    endcase
  endfunction

  function automatic int first_of(logic [W-1:0] w);
    return (w[3:1] == 3'd0) ? 0 : 1;
  endfunction

  function automatic logic [W-1:0] mk_mode(int mb, int rt, bit bt, bit st, bit aor);
    logic [W-1:0] w;
    w = {17'h1B3C5, 16'h0};
    w[15:10] = 6'h2D;
    w[3:1] = mb[2:0];
    w[6:4] = rt[2:0];
    w[7] = bt;
    w[8] = st;
    w[9] = aor;
    w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic [W-1:0] dat(int k);
    logic [31:0] v;
    v = 32'(32'h9E3779B9 * (k + 1)) ^ 32'h5A5A0F0F;
    return {v, 1'b1};
  endfunction

  task automatic check(string nm, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic m_unit(int b, bit refr, bit frc);
    if (refr) m_mode = mm[0];
    m_blk = b; q.delete(); m_inst = 0; m_cnt = 0; m_st = 2;
    if (m_mode[7] || (frc && m_mode[8])) begin q.push_back(100); q.push_back(101); end
    for (int i = 0; i < 32; i++) q.push_back(i);
  endtask

  task automatic m_step();
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_blk = 0; m_mode = '0; q.delete(); m_inst = 0;
    end else if (stop_i) begin
      m_st = 3;
    end else if (m_st == 3) begin
      m_st = 3;
    end else if (rsm_i && m_st != 0) begin
      if (rsm_err) m_unit(first_of(mm[0]), 1, 0);
      else m_unit(int'(rsm_blk), !rsm_mchg, 1);
    end else if (wake_i && m_st == 1) begin
      m_unit(first_of(mm[0]), 1, 0);
    end else if (m_st == 0) begin
      if (m_cnt == SU - 1) begin
        if (mm[0][9]) begin m_mode = mm[0]; m_st = 1; m_cnt = 0; end
        else m_unit(first_of(mm[0]), 1, 0);
      end else m_cnt++;
    end else if (m_st == 2) begin
      if (m_cnt == period(m_mode[6:4]) - 1) begin
        void'(q.pop_front());
        m_cnt = 0;
        if (q.size() == 0) begin
          if (m_inst) m_unit(first_of(mm[0]), 1, 0);
          else if (m_blk < int'(m_mode[3:1])) m_unit(m_blk + 1, 1, 0);
          else if (m_mode[8] && m_mode[3:1] != 3'd0) begin
            repeat (2) begin q.push_back(100); q.push_back(101); end
            m_inst = 1;
          end else m_unit(first_of(mm[0]), 1, 0);
        end
      end else m_cnt++;
    end
    if (pl_we) mm[pl_addr] = pl_data;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_en, e_clk, e_damp, e_bit;
      int sym;
      e_en   = (m_st == 2);
      sym    = e_en ? q[0] : 0;
      e_clk  = e_en && (m_cnt == 0);
      e_damp = e_en && (sym == 100);
      e_bit  = e_en && ((sym == 101) || (sym < 100 && mm[m_blk][sym + 1]));
      check("mod_en", 64'(mod_en), 64'(e_en));
      check("bit_clk", 64'(bit_clk), 64'(e_clk));
      check("tx_damp", 64'(tx_damp), 64'(e_damp));
      check("tx_bit", 64'(tx_bit), 64'(e_bit));
      check("cur_blk", 64'(cur_blk), 64'(m_blk));
      check("mode_o", 64'(mode_o), 64'(m_mode));
    end
    m_step();
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    pl_we = 1'b1; pl_addr = a[2:0]; pl_data = d;
    tick(1);
    pl_we = 1'b0;
  endtask

  task automatic resume(int b, bit err, bit mchg);
    rsm_i = 1'b1; rsm_blk = b[2:0]; rsm_err = err; rsm_mchg = mchg;
    tick(1);
    rsm_i = 1'b0; rsm_err = 1'b0; rsm_mchg = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_i = 1'b1; tick(1); wake_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] old_m;
    tick(2);
    for (int k = 1; k < NB; k++) wr(k, dat(k));
    wr(0, mk_mode(3, 0, 0, 0, 0));
    req = "R1";
    check("reset mod_en", 64'(mod_en), 64'(0));
    check("reset tx_damp", 64'(tx_damp), 64'(0));
    check("reset mode_o", 64'(mode_o), 64'(0));
    rst_n = 1'b1;
    req = "R1 R2 R3 R4";
    tick(255);
    check("mod_en before window end", 64'(mod_en), 64'(0));
    tick(1);
    check("mod_en at window end", 64'(mod_en), 64'(1));
    check("first bit_clk", 64'(bit_clk), 64'(1));
    check("first word", 64'(cur_blk), 64'(1));
    check("R2 mode loaded", 64'(mode_o), 64'(mk_mode(3, 0, 0, 0, 0)));
    // R9: mid-word write to word 0 must not show until next word
    req = "R9";
    tick(100);
    old_m = mode_o;
    wr(0, mk_mode(3, 2, 0, 0, 0));
    check("mode held mid-word", 64'(mode_o), 64'(old_m));
    tick(3300);
    // R5 with a 16-clock rate and block terminators (R7)
    req = "R5 R7";
    wr(0, mk_mode(2, 1, 1, 0, 0));
    tick(2400);
    // R8 sequence terminators
    req = "R8";
    wr(0, mk_mode(2, 0, 1, 1, 0));
    tick(1600);
    wr(0, mk_mode(3, 0, 0, 1, 0));
    tick(1200);
    // R6 LAST = 0
    req = "R6";
    wr(0, mk_mode(0, 0, 0, 1, 0));
    tick(900);
    check("word 0 repeats", 64'(cur_blk), 64'(0));
    // R10 resume after programming and after error
    req = "R10";
    wr(0, mk_mode(3, 0, 0, 1, 0));
    tick(400);
    resume(6, 0, 0);
    check("resumed word", 64'(cur_blk), 64'(6));
    check("forced terminator", 64'(tx_damp), 64'(1));
    tick(700);
    resume(5, 1, 0);
    check("error resume head", 64'(cur_blk), 64'(1));
    tick(400);
    // R11 word 0 reprogrammed
    req = "R11";
    old_m = mode_o;
    wr(0, mk_mode(2, 1, 1, 0, 0));
    resume(0, 0, 1);
    check("old mode kept", 64'(mode_o), 64'(old_m));
    tick(1200);
    // R14 resume on the last clock of a word
    req = "R14";
    wr(0, mk_mode(2, 0, 0, 1, 0));
    tick(300);
    for (int n = 0; n < 2000; n++) begin
      if (m_st == 2 && !m_inst && m_blk == 2 && q.size() == 1 &&
          m_cnt == period(m_mode[6:4]) - 1) break;
      tick(1);
    end
    resume(5, 0, 0);
    check("boundary resume word", 64'(cur_blk), 64'(5));
    tick(800);
    // R12 answer-on-request
    req = "R12";
    rst_n = 1'b0;
    wr(0, mk_mode(2, 0, 0, 0, 1));
    rst_n = 1'b1;
    tick(1500);
    check("silent", 64'(mod_en), 64'(0));
    pulse_wake();
    check("woken", 64'(mod_en), 64'(1));
    check("wake head", 64'(cur_blk), 64'(1));
    tick(600);
    // R13 R14 stop and resume on one edge
    req = "R13 R14";
    stop_i = 1'b1; rsm_i = 1'b1; rsm_blk = 3'd4;
    tick(1);
    stop_i = 1'b0; rsm_i = 1'b0;
    check("stopped", 64'(mod_en), 64'(0));
    tick(50);
    pulse_wake();
    tick(20);
    resume(3, 0, 0);
    tick(200);
    check("still stopped", 64'(mod_en), 64'(0));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule